// File: doc/BRIEF.md
# Masked BSSID Receive Address Filter

This block decides, frame by frame, whether a received network identifier (BSSID) belongs to the station and so should be acknowledged. Software programs a 48-bit station address and a 48-bit select mask over a 32-bit register port. Each 48-bit value is split over two registers: a low word with address bytes 0 to 3 and an upper register with bytes 4 to 5 in its lower half. A frame is accepted when the bits picked out by the mask agree between the frame identifier and the station address. Bits outside the mask are ignored. With an all-ones mask only an exact match passes. With a sparser mask, several virtual networks can share one station address. Any identifier that agrees on the selected bits also passes, even one not addressed to the station.

Frame identifiers arrive on a valid/ready stream and verdicts leave on a second valid/ready stream through a single output register. The input is ready whenever that register is empty or is being drained in the same cycle. So back-pressure on the verdict side stalls the identifier side with no extra buffering. A verdict appears one cycle after its identifier is taken and stays unchanged until it is consumed. Two saturating counters, one for accepted frames and one for rejected frames, can be read back through the register port.

Top module: `bssid_filter`

## Requirements
- R1: After reset, the station address reads 0 (word 0 = 0x00000000, word 1 = 0x00000000), the mask reads all ones (word 2 = 0xFFFFFFFF, word 3 = 0x0000FFFF), both counters read 0, and no verdict is valid.
- R2: Register word addresses are 0 for address bytes 0-3, 1 for address bytes 4-5, 2 for mask bytes 0-3, 3 for mask bytes 4-5, 4 for the accept count and 5 for the reject count. Byte order is little-endian: byte 0 is in bits [7:0] of the low word and of the frame identifier bus, and byte 4 is in bits [7:0] of the upper register.
- R3: A write to word 1 or word 3 stores only data bits [15:0]. A read of either word returns 0 in bits [31:16].
- R4: The verdict is 1 exactly when (frame identifier AND mask) equals (station address AND mask), and 0 otherwise.
- R5: With the all-ones mask, only an identifier equal to the station address in all 48 bits is accepted. A single differing bit, low or high, causes rejection.
- R6: Loose matching: with station address 0x111111111111 and mask 0x222222222222, identifiers 0x111111111111, 0x444444444444, 0x999999999999 and 0xDDDDDDDDDDDD are accepted and 0x666666666666 is rejected.
- R7: A register write takes effect for identifiers taken in later cycles. An identifier taken in the same cycle as the write is judged with the old value.
- R8: An identifier is taken when frm_valid and frm_ready are both high. Its verdict is valid on the next cycle. frm_ready is high when no verdict is pending or the pending verdict is consumed in the same cycle. A pending verdict holds its value until vrd_ready is high.
- R9: Each taken identifier adds one to the accept count or to the reject count, according to its verdict. Each count stops at 2^CNT_W-1 and stays there. A read returns the count zero-extended to 32 bits.
- R10: Writes to the counter words (4 and 5) or to unmapped words (6 and 7) change no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register write word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register read word address |
| cfg_rdata | output | 32 | Register read data (combinational) |
| frm_valid | input | 1 | Frame identifier valid |
| frm_ready | output | 1 | Frame identifier ready |
| frm_bssid | input | 48 | Frame identifier, byte 0 in bits [7:0] |
| vrd_valid | output | 1 | Verdict valid |
| vrd_ready | input | 1 | Verdict ready |
| vrd_accept | output | 1 | Verdict: 1 = accept, 0 = reject |

## Verification
The assertions assume that reset is applied at the start and that the downstream side obeys valid/ready: a verdict counts as consumed only at a clock edge where vrd_ready is high. They place no constraint on frm_valid being held, because the block never drops a pending identifier without frm_ready. The stimulus changes inputs only on the falling clock edge. It keeps frm_valid and frm_bssid unchanged until frm_ready is seen high, and it switches vrd_ready through a fixed pattern so that stalls are exercised without losing any verdict.

// File: rtl/bssid_filter_pkg.sv
package bssid_filter_pkg;
  localparam int ID_BYTES = 6;
  localparam int ID_W     = ID_BYTES * 8;
  localparam int WORD_W   = 32;
  localparam int HI_W     = ID_W - WORD_W;
  localparam int REG_AW   = 3;

  localparam logic [REG_AW-1:0] A_MAC_LO  = 3'd0;
  localparam logic [REG_AW-1:0] A_MAC_HI  = 3'd1;
  localparam logic [REG_AW-1:0] A_MASK_LO = 3'd2;
  localparam logic [REG_AW-1:0] A_MASK_HI = 3'd3;
  localparam logic [REG_AW-1:0] A_ACC_CNT = 3'd4;
  localparam logic [REG_AW-1:0] A_REJ_CNT = 3'd5;

  typedef struct packed {
    logic valid;
    logic accept;
  } verdict_t;
endpackage

// File: rtl/bssid_cfg_regs.sv
module bssid_cfg_regs
  import bssid_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [ID_W-1:0]   sta_addr,
  output logic [ID_W-1:0]   sel_mask
);
  logic [WORD_W-1:0] addr_lo_q, mask_lo_q;
  logic [HI_W-1:0]   addr_hi_q, mask_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      mask_lo_q <= '1;
      mask_hi_q <= '1;
    end else if (we) begin
      unique case (addr)
        A_MAC_LO:  addr_lo_q <= wdata;
        A_MAC_HI:  addr_hi_q <= wdata[HI_W-1:0];
        A_MASK_LO: mask_lo_q <= wdata;
        A_MASK_HI: mask_hi_q <= wdata[HI_W-1:0];
        default:   ;
      endcase
    end
  end

  assign sta_addr = {addr_hi_q, addr_lo_q};
  assign sel_mask = {mask_hi_q, mask_lo_q};
endmodule

// File: rtl/bssid_mask_match.sv
module bssid_mask_match
  import bssid_filter_pkg::*;
(
  input  logic [ID_W-1:0] frame_id,
  input  logic [ID_W-1:0] sta_addr,
  input  logic [ID_W-1:0] sel_mask,
  output logic            hit
);
  logic [ID_BYTES-1:0] lane_ok;

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_lane
    logic [7:0] diff;
    assign diff       = (frame_id[g*8 +: 8] ^ sta_addr[g*8 +: 8]) & sel_mask[g*8 +: 8];
    assign lane_ok[g] = (diff == 8'h00);
  end

  assign hit = &lane_ok;
endmodule

// File: rtl/bssid_sat_counter.sv
module bssid_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/bssid_filter.sv
module bssid_filter
  import bssid_filter_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic [REG_AW-1:0] cfg_raddr,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [ID_W-1:0]   frm_bssid,
  output logic              vrd_valid,
  input  logic              vrd_ready,
  output logic              vrd_accept
);
  logic [ID_W-1:0]  sta_addr, sel_mask;
  logic             hit, take;
  logic [CNT_W-1:0] acc_cnt, rej_cnt;
  verdict_t         out_q;

  bssid_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .sta_addr(sta_addr), .sel_mask(sel_mask)
  );

  bssid_mask_match u_match (
    .frame_id(frm_bssid), .sta_addr(sta_addr), .sel_mask(sel_mask), .hit(hit)
  );

  assign frm_ready = !out_q.valid || vrd_ready;
  assign take      = frm_valid && frm_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (take) begin
      out_q.valid  <= 1'b1;
      out_q.accept <= hit;
    end else if (vrd_ready) begin
      out_q.valid <= 1'b0;
    end
  end

  assign vrd_valid  = out_q.valid;
  assign vrd_accept = out_q.accept;

  bssid_sat_counter #(.W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .inc(take && hit), .count(acc_cnt)
  );
  bssid_sat_counter #(.W(CNT_W)) u_rej (
    .clk(clk), .rst_n(rst_n), .inc(take && !hit), .count(rej_cnt)
  );

  always_comb begin
    unique case (cfg_raddr)
      A_MAC_LO:  cfg_rdata = sta_addr[WORD_W-1:0];
      A_MAC_HI:  cfg_rdata = {{(2*WORD_W-ID_W){1'b0}}, sta_addr[ID_W-1:WORD_W]};
      A_MASK_LO: cfg_rdata = sel_mask[WORD_W-1:0];
      A_MASK_HI: cfg_rdata = {{(2*WORD_W-ID_W){1'b0}}, sel_mask[ID_W-1:WORD_W]};
      A_ACC_CNT: cfg_rdata = WORD_W'(acc_cnt);
      A_REJ_CNT: cfg_rdata = WORD_W'(rej_cnt);
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bssid_filter_chk.sv
module bssid_filter_chk
  import bssid_filter_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic [ID_W-1:0]   frm_bssid,
  input logic              vrd_valid,
  input logic              vrd_ready,
  input logic              vrd_accept,
  input logic [REG_AW-1:0] cfg_raddr,
  input logic [WORD_W-1:0] cfg_rdata,
  input logic [ID_W-1:0]   sta_addr,
  input logic [ID_W-1:0]   sel_mask,
  input logic [CNT_W-1:0]  acc_cnt,
  input logic [CNT_W-1:0]  rej_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  logic took;
  assign took = frm_valid && frm_ready;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !vrd_valid); // R1
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_raddr == A_MAC_HI || cfg_raddr == A_MASK_HI) |-> cfg_rdata[31:16] == 16'h0); // R3
  AST_MASKED_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> vrd_accept == $past(((frm_bssid ^ sta_addr) & sel_mask) == '0)); // R4
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) took |=> vrd_valid); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_valid && !vrd_ready) |=> (vrd_valid && $stable(vrd_accept))); // R8
  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !vrd_valid |-> frm_ready); // R8
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (took && acc_cnt != CMAX && ((frm_bssid ^ sta_addr) & sel_mask) == '0)
      |=> acc_cnt == $past(acc_cnt) + 1'b1); // R9
  AST_ACC_SAT: assert property (@(posedge clk) disable iff (!rst_n) acc_cnt == CMAX |=> acc_cnt == CMAX); // R9
  AST_REJ_SAT: assert property (@(posedge clk) disable iff (!rst_n) rej_cnt == CMAX |=> rej_cnt == CMAX); // R9
  AST_IDLE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> ($stable(acc_cnt) && $stable(rej_cnt))); // R9
endmodule

bind bssid_filter bssid_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
  .frm_bssid(frm_bssid), .vrd_valid(vrd_valid), .vrd_ready(vrd_ready),
  .vrd_accept(vrd_accept), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
  .sta_addr(sta_addr), .sel_mask(sel_mask), .acc_cnt(acc_cnt), .rej_cnt(rej_cnt)
);

// File: tb/bssid_filter_test.sv
`timescale 1ns/1ps
module bssid_filter_test;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [47:0] frm_bssid = '0;
  logic        vrd_valid;
  logic        vrd_ready = 1'b1;
  logic        vrd_accept;

  int n_chk = 0, n_fail = 0, n_acc = 0, n_rej = 0;
  bit bp_mode = 1'b0;
  logic  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  bssid_filter #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_bssid(frm_bssid), .vrd_valid(vrd_valid), .vrd_ready(vrd_ready), .vrd_accept(vrd_accept)
  );

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Back-pressure pattern applied just after each rising edge.
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #2;
      k++;
      vrd_ready = bp_mode ? (k % 3 != 0) : 1'b1;
    end
  end

  // Monitor: pops the scoreboard whenever a verdict is consumed.
  always @(negedge clk) begin
    if (rst_n && vrd_valid && vrd_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected verdict", 48'(vrd_accept), 48'h0);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(vrd_accept == e, t, 48'(vrd_accept), 48'(e));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    cfg_raddr = a;
    #1;
    check(cfg_rdata == e, tag, 48'(cfg_rdata), 48'(e));
  endtask

  task automatic set_pair(input logic [2:0] lo, input logic [47:0] v);
    wr(lo, v[31:0]);
    wr(lo + 3'd1, {16'hBEEF, v[47:32]});
  endtask

  task automatic send(input logic [47:0] b, input logic e, input string tag);
    @(negedge clk);
    frm_valid = 1'b1; frm_bssid = b;
    exp_q.push_back(e); tag_q.push_back(tag);
    if (e) n_acc++; else n_rej++;
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  initial begin
    #2_000_000;
    check(1'b0, "watchdog expired", 48'h0, 48'h1);
    summary();
  end

  initial begin
    logic [47:0] mac, msk;
    repeat (3) @(negedge clk);
    #1 check(vrd_valid == 1'b0, "R1 verdict idle in reset", 48'(vrd_valid), 48'h0);
    rst_n = 1'b1;
    rd_chk(3'd0, 32'h0, "R1 address low");
    rd_chk(3'd1, 32'h0, "R1 address high");
    rd_chk(3'd2, 32'hFFFFFFFF, "R1 mask low");
    rd_chk(3'd3, 32'h0000FFFF, "R1 mask high");
    rd_chk(3'd4, 32'h0, "R1 accept count");
    rd_chk(3'd5, 32'h0, "R1 reject count");
    check(vrd_valid == 1'b0, "R1 verdict idle after reset", 48'(vrd_valid), 48'h0);

    // R2 / R3: little-endian split, upper half ignored
    wr(3'd0, 32'h44332211);
    wr(3'd1, 32'hABCD6655);
    rd_chk(3'd1, 32'h00006655, "R3 address high upper bits dropped");
    wr(3'd3, 32'h1234FFFF);
    rd_chk(3'd3, 32'h0000FFFF, "R3 mask high upper bits dropped");
    send(48'h665544332211, 1'b1, "R2 byte order exact match");
    send(48'h665544332210, 1'b0, "R5 low bit differs");
    send(48'hE65544332211, 1'b0, "R5 top bit differs");
    drain();
    rd_chk(3'd4, 32'(sat(n_acc)), "R9 accept count");
    rd_chk(3'd5, 32'(sat(n_rej)), "R9 reject count");

    // R10: writes to read-only and unmapped words
    wr(3'd4, 32'h000000FF);
    wr(3'd5, 32'h000000FF);
    wr(3'd6, 32'hFFFFFFFF);
    wr(3'd7, 32'hFFFFFFFF);
    rd_chk(3'd4, 32'(sat(n_acc)), "R10 accept count unchanged");
    rd_chk(3'd5, 32'(sat(n_rej)), "R10 reject count unchanged");
    rd_chk(3'd0, 32'h44332211, "R10 address low unchanged");
    rd_chk(3'd2, 32'hFFFFFFFF, "R10 mask low unchanged");

    // R6: loose matching example scaled to 48 bits
    set_pair(3'd0, 48'h111111111111);
    set_pair(3'd2, 48'h222222222222);
    send(48'h111111111111, 1'b1, "R6 own address");
    send(48'h444444444444, 1'b1, "R6 pattern 4");
    send(48'h999999999999, 1'b1, "R6 pattern 9");
    send(48'hDDDDDDDDDDDD, 1'b1, "R6 pattern D");
    send(48'h666666666666, 1'b0, "R6 pattern 6 rejected");
    drain();
    rd_chk(3'd4, 32'(sat(n_acc)), "R9 accept count mid");
    rd_chk(3'd5, 32'(sat(n_rej)), "R9 reject count mid");

    // R4 / R8: mixed identifiers under back-pressure
    mac = 48'h0A1B2C3D4E5F;
    msk = 48'hF0F0FF00FF0F;
    set_pair(3'd0, mac);
    set_pair(3'd2, msk);
    bp_mode = 1'b1;
    for (int i = 0; i < 24; i++) begin
      logic [47:0] r, b;
      r = {$urandom(), $urandom()} >> 16;
      b = (i % 2 == 0) ? (mac ^ (r & ~msk)) : (mac ^ r);
      send(b, ((b ^ mac) & msk) == 48'h0, "R4 masked compare");
    end
    drain();
    bp_mode = 1'b0;
    repeat (2) @(negedge clk);

    // R7: write and identifier in the same cycle
    set_pair(3'd0, 48'h0);
    set_pair(3'd2, 48'hFFFFFFFFFFFF);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h5;
    frm_valid = 1'b1; frm_bssid = 48'h0;
    exp_q.push_back(1'b1); tag_q.push_back("R7 same-cycle write uses old address"); n_acc++;
    @(negedge clk);
    cfg_we = 1'b0;
    exp_q.push_back(1'b0); tag_q.push_back("R7 next cycle uses new address"); n_rej++;
    @(negedge clk);
    frm_valid = 1'b0;
    drain();

    // R9: saturation
    for (int i = 0; i < 16; i++) send(48'h5, 1'b1, "R9 accept fill");
    for (int i = 0; i < 16; i++) send(48'h4, 1'b0, "R9 reject fill");
    drain();
    rd_chk(3'd4, 32'(CMAX), "R9 accept count saturated");
    rd_chk(3'd5, 32'(CMAX), "R9 reject count saturated");
    summary();
  end
endmodule